// File: doc/BRIEF.md
# PCM Frame Elastic Store

This block carries aligned 2.048 Mbit/s PCM-30 data from the line-recovered clock domain into the local system clock domain. On the write side, serial bits arrive with a strobe and the bit index within their time slot. Each finished time slot is stored as one byte plus an even parity bit in a circular store of 48 slots, which is one and a half frames. A Gray-coded copy of the write slot counter crosses into the read domain, so that the read side can measure how far it trails the writer.

On the read side, the output frame phase is set by a host trigger. The trigger is an active-low pulse, given on alternate frames in the bit interval just before output slot zero, and it only counts while chip enable (active low) is asserted. After that the block presents one slot every eight system clocks: serially with the sign bit first, and as a parallel byte with its stored parity bit behind an output enable that follows chip enable.

When the read side comes too close to the writer, or lags too far behind it, the read index jumps by half of the active store (a controlled slip) and a one-cycle slip pulse is raised. With buffer inhibit asserted, the usable lag is cut to one frame, so that the output stays within a frame of the input.

Top module: `pcm_elastic_store`

## Requirements
- R1: After reset, and until the first accepted trigger, `par_out`, `par_bit`, `ser_out` and `slip` stay 0, even while slots are being written.
- R2: A trigger is `sct_n` low while `ce_n` is low at a `sclk` edge. That edge loads the next unread slot (slot 0 for the first trigger after reset) and restarts the eight-clock slot timing, even in the middle of a slot.
- R3: `sct_n` low while `ce_n` is high has no effect: the slot being shifted out and the slot sequence continue unchanged.
- R4: `ser_out` sends each slot with the sign bit first, one bit per `sclk`, eight bits per slot, and the next slot starts exactly eight clocks after the previous one.
- R5: `par_out` holds the current slot for its whole eight-clock interval. Bit 7 is the first bit received (sign) and bit 0 is the last (LSB).
- R6: `par_bit` is the parity bit stored with the slot, chosen so that `par_out` together with `par_bit` has an even number of ones.
- R7: `par_oe` is 1 exactly when `ce_n` is 0.
- R8: A bit is captured on each `wclk` edge with `wr_vld` high. When `wr_bitpos` is 7, the slot closes. Slots go into consecutive positions of a 48-slot ring and, without slips, are read out in the order they were written.
- R9: At each slot load, lag = (slots written − read index) mod 48. If lag < 2, the slot read is the one half a store back (24 slots in normal mode), and `slip` is high for the one cycle that starts with that slot.
- R10: If lag exceeds 46 in normal mode, or 31 with `buf_inh` high, the read index jumps forward by the half-store amount and `slip` pulses as in R9.
- R11: `buf_inh` high sets the jump amount to 16 slots and the lag limit to 31. `buf_inh` low sets them to 24 and 46.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-recovered write clock |
| wrst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_vld | input | 1 | Input bit valid strobe |
| wr_bit | input | 1 | Serial input data bit |
| wr_bitpos | input | 3 | Index of the bit within its time slot (7 closes the slot) |
| sclk | input | 1 | System clock for the read side |
| srst_n | input | 1 | Read-domain synchronous reset, active low |
| sct_n | input | 1 | Output frame trigger, active low |
| ce_n | input | 1 | Chip enable, active low; gates the trigger and parallel outputs |
| buf_inh | input | 1 | Buffer inhibit: reduced lag limit and jump |
| ser_out | output | 1 | Retimed serial data, sign bit first |
| par_out | output | 8 | Current slot, bit 7 sign, bit 0 LSB |
| par_bit | output | 1 | Stored even-parity bit of the current slot |
| par_oe | output | 1 | Drive enable for `par_out` and `par_bit` |
| slip | output | 1 | One-cycle pulse when a controlled slip is taken |

## Verification
A trigger or slot boundary takes effect at the `sclk` edge that samples it. So the new `par_out`, `par_bit`, `slip` and the sign bit on `ser_out` are due one half-cycle later, and each further serial bit follows one clock after the previous one. The bench drives stimulus and samples on falling edges. It starts each slot check on the falling edge that follows the loading edge and steps eight falling edges per slot. Slip scenarios stop the writer at a slot boundary and wait several clocks before the trigger, so the synchronised write count is settled. The lag at every load can then be computed exactly from the number of slots written and read.

// File: rtl/pcm_es_pkg.sv
// Shared definitions for the PCM frame elastic store.
// Assumes 8-bit time slots; a stored word is the slot byte plus its parity bit.
package pcm_es_pkg;
    localparam int SLOT_BITS = 8;
    localparam int POS_W     = $clog2(SLOT_BITS);

    typedef struct packed {
        logic                 par;
        logic [SLOT_BITS-1:0] data;
    } slot_word_t;
endpackage

// File: rtl/pcm_es_wr.sv
// Write side: deserialises input bits into slots, adds even parity,
// and advances a slot counter whose Gray copy is safe to synchronise.
// Assumes DEPTH is even and below 2**AW. The counter runs from OFS to
// OFS+DEPTH-1, so its Gray code changes by a single bit at the wrap too.
module pcm_es_wr
    import pcm_es_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int AW    = 6,
    parameter int OFS   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             bit_i,
    input  logic [POS_W-1:0] bitpos,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output slot_word_t       wword,
    output logic [AW-1:0]    wgray
);
    localparam logic [AW-1:0] CNT_LO = AW'(OFS);
    localparam logic [AW-1:0] CNT_HI = AW'(OFS + DEPTH - 1);

    logic [SLOT_BITS-2:0] shreg;
    logic [AW-1:0]        wcnt;
    logic [AW-1:0]        wcnt_nxt;

    // Next counter value with wrap inside the symmetric window.
    always_comb begin
        wcnt_nxt = (wcnt == CNT_HI) ? CNT_LO : wcnt + AW'(1);
    end

    // Slot closes on the last bit; the word written includes that bit.
    always_comb begin
        we         = vld && (bitpos == POS_W'(SLOT_BITS - 1));
        wword.data = {shreg, bit_i};
        wword.par  = ^{shreg, bit_i};
        waddr      = wcnt - CNT_LO;
    end

    // Bit shifter, slot counter and its registered Gray image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            wcnt  <= CNT_LO;
            wgray <= CNT_LO ^ (CNT_LO >> 1);
        end else if (vld) begin
            shreg <= {shreg[SLOT_BITS-3:0], bit_i};
            if (we) begin
                wcnt  <= wcnt_nxt;
                wgray <= wcnt_nxt ^ (wcnt_nxt >> 1);
            end
        end
    end
endmodule

// File: rtl/pcm_es_ram.sv
// Slot store: one write port in the write clock domain, combinational read.
// Assumes a slot is read only after it has been written at least once.
module pcm_es_ram
    import pcm_es_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int AW    = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  slot_word_t    wword,
    input  logic [AW-1:0] raddr,
    output slot_word_t    rword
);
    slot_word_t mem [DEPTH];

    // Store a completed slot.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wword;
    end

    assign rword = mem[raddr];
endmodule

// File: rtl/pcm_es_sync.sv
// Two-stage synchroniser for a Gray-coded bus.
// Assumes at most one bit of the bus changes between source clock edges.
module pcm_es_sync #(
    parameter int             W       = 6,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pcm_es_rd.sv
// Read side: slot timing from the host trigger, serial and parallel output,
// and the slip decision from the lag to the synchronised write counter.
// Assumes wgray_s lies within the counter window used by pcm_es_wr.
module pcm_es_rd
    import pcm_es_pkg::*;
#(
    parameter int DEPTH       = 48,
    parameter int FRAME_SLOTS = 32,
    parameter int MIN_LAG     = 2,
    parameter int AW          = 6,
    parameter int OFS         = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sct_n,
    input  logic                 ce_n,
    input  logic                 buf_inh,
    input  logic [AW-1:0]        wgray_s,
    input  slot_word_t           rword,
    output logic [AW-1:0]        raddr,
    output logic                 ser_out,
    output logic [SLOT_BITS-1:0] par_out,
    output logic                 par_bit,
    output logic                 slip,
    output logic                 run,
    output logic                 ld,
    output logic [POS_W-1:0]     bit_lo
);
    localparam logic [AW:0] DEP   = (AW+1)'(DEPTH);
    localparam logic [AW:0] J_NRM = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] J_INH = (AW+1)'(FRAME_SLOTS / 2);
    localparam logic [AW:0] M_NRM = (AW+1)'(DEPTH - 2);
    localparam logic [AW:0] M_INH = (AW+1)'(FRAME_SLOTS - 1);
    localparam logic [AW:0] M_LOW = (AW+1)'(MIN_LAG);

    logic [AW-1:0]        rptr;
    logic [AW-1:0]        wbin;
    logic [AW:0]          lag, jmp, lag_max, fwd, back;
    logic                 under, over, trig;
    logic [SLOT_BITS-1:0] shreg;

    // Gray to binary, then remove the counter window offset.
    always_comb begin
        logic [AW-1:0] b;
        b[AW-1] = wgray_s[AW-1];
        for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ wgray_s[i];
        wbin = b - AW'(OFS);
    end

    // Lag to the writer and the slip choice for this load.
    always_comb begin
        lag = {1'b0, wbin} - {1'b0, rptr};
        if (lag[AW]) lag = lag + DEP;
        jmp     = buf_inh ? J_INH : J_NRM;
        lag_max = buf_inh ? M_INH : M_NRM;
        under   = lag < M_LOW;
        over    = lag > lag_max;
        fwd     = {1'b0, rptr} + jmp;
        if (fwd >= DEP) fwd = fwd - DEP;
        back    = ({1'b0, rptr} >= jmp) ? {1'b0, rptr} - jmp : {1'b0, rptr} + DEP - jmp;
        if (under)     raddr = back[AW-1:0];
        else if (over) raddr = fwd[AW-1:0];
        else           raddr = rptr;
    end

    // Load on an accepted trigger or at the last bit of a running slot.
    always_comb begin
        trig    = !sct_n && !ce_n;
        ld      = trig || (run && bit_lo == POS_W'(SLOT_BITS - 1));
        ser_out = shreg[SLOT_BITS-1];
    end

    // Slot timing, read index, output registers and slip pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            bit_lo  <= '0;
            run     <= 1'b0;
            shreg   <= '0;
            par_out <= '0;
            par_bit <= 1'b0;
            slip    <= 1'b0;
        end else begin
            if (trig)     bit_lo <= '0;
            else if (run) bit_lo <= bit_lo + POS_W'(1);
            if (ld) begin
                run     <= 1'b1;
                shreg   <= rword.data;
                par_out <= rword.data;
                par_bit <= rword.par;
                slip    <= under || over;
                rptr    <= (raddr == AW'(DEPTH - 1)) ? '0 : raddr + AW'(1);
            end else begin
                shreg   <= {shreg[SLOT_BITS-2:0], 1'b0};
                slip    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcm_elastic_store.sv
// PCM frame elastic store: moves slots from the write clock domain to the
// system clock domain through a one-and-a-half frame ring, with a host-set
// output phase and controlled slips. Assumes DEPTH is even and that both
// domains run at the same nominal bit rate.
module pcm_elastic_store
    import pcm_es_pkg::*;
#(
    parameter int DEPTH       = 48,
    parameter int FRAME_SLOTS = 32,
    parameter int MIN_LAG     = 2
) (
    input  logic                 wclk,
    input  logic                 wrst_n,
    input  logic                 wr_vld,
    input  logic                 wr_bit,
    input  logic [POS_W-1:0]     wr_bitpos,
    input  logic                 sclk,
    input  logic                 srst_n,
    input  logic                 sct_n,
    input  logic                 ce_n,
    input  logic                 buf_inh,
    output logic                 ser_out,
    output logic [SLOT_BITS-1:0] par_out,
    output logic                 par_bit,
    output logic                 par_oe,
    output logic                 slip
);
    localparam int            AW     = $clog2(DEPTH);
    localparam int            OFS    = (2**AW - DEPTH) / 2;
    localparam logic [AW-1:0] OFS_V  = AW'(OFS);
    localparam logic [AW-1:0] GRAY_R = OFS_V ^ (OFS_V >> 1);

    logic             w_we;
    logic [AW-1:0]    w_addr, w_gray, s_gray, r_addr;
    slot_word_t       w_word, r_word;
    logic             rd_run, rd_ld;
    logic [POS_W-1:0] rd_bit_lo;

    pcm_es_wr #(.DEPTH(DEPTH), .AW(AW), .OFS(OFS)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .vld(wr_vld), .bit_i(wr_bit),
        .bitpos(wr_bitpos), .we(w_we), .waddr(w_addr), .wword(w_word),
        .wgray(w_gray)
    );

    pcm_es_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .wclk(wclk), .we(w_we), .waddr(w_addr), .wword(w_word),
        .raddr(r_addr), .rword(r_word)
    );

    pcm_es_sync #(.W(AW), .RST_VAL(GRAY_R)) u_sync (
        .clk(sclk), .rst_n(srst_n), .d(w_gray), .q(s_gray)
    );

    pcm_es_rd #(
        .DEPTH(DEPTH), .FRAME_SLOTS(FRAME_SLOTS), .MIN_LAG(MIN_LAG),
        .AW(AW), .OFS(OFS)
    ) u_rd (
        .clk(sclk), .rst_n(srst_n), .sct_n(sct_n), .ce_n(ce_n),
        .buf_inh(buf_inh), .wgray_s(s_gray), .rword(r_word),
        .raddr(r_addr), .ser_out(ser_out), .par_out(par_out),
        .par_bit(par_bit), .slip(slip), .run(rd_run), .ld(rd_ld),
        .bit_lo(rd_bit_lo)
    );

    assign par_oe = !ce_n;
endmodule

// File: rtl/pcm_es_checker.sv
// Protocol checks on the read side of the elastic store, bound to the top.
module pcm_es_checker
    import pcm_es_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce_n,
    input logic                 run,
    input logic                 ld,
    input logic [POS_W-1:0]     bit_lo,
    input logic                 ser_out,
    input logic [SLOT_BITS-1:0] par_out,
    input logic                 par_bit,
    input logic                 slip
);
    // R1: nothing leaves the block before the first accepted trigger
    p_quiet_before_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (par_out == '0 && !slip && !ser_out && !par_bit));

    // R4: the first serial bit of a slot is its sign bit
    p_sign_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ld) |-> ser_out == par_out[SLOT_BITS-1]);

    // R5: the parallel word only changes at a slot load
    p_slot_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld) |-> $stable(par_out));

    // R6: stored parity keeps the nine output bits even
    p_even_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(^{par_out, par_bit}));

    // R9: a slip pulse only follows a slot load
    p_slip_on_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slip |-> $past(ld));

    // R3: with chip enable off, mid-slot, the parallel word does not move
    p_trig_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ce_n && bit_lo != POS_W'(SLOT_BITS - 1)) |=> $stable(par_out));
endmodule

bind pcm_elastic_store pcm_es_checker i_chk (
    .clk(sclk), .rst_n(srst_n), .ce_n(ce_n), .run(rd_run), .ld(rd_ld),
    .bit_lo(rd_bit_lo), .ser_out(ser_out), .par_out(par_out),
    .par_bit(par_bit), .slip(slip)
);

// File: tb/test_pcm_elastic_store.sv
// Directed bench for the PCM frame elastic store; both domains share one clock.
module test_pcm_elastic_store;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_vld = 1'b0, wr_bit = 1'b0;
    logic [2:0] wr_bitpos = '0;
    logic       sct_n = 1'b1, ce_n = 1'b0, buf_inh = 1'b0;
    logic       ser_out, par_bit, par_oe, slip;
    logic [7:0] par_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Background writer state
    bit wr_on = 0;
    int wr_slot = 0, wr_idx = 0, wr_limit = 0, seed = 0;

    always #4 clk = ~clk;

    pcm_elastic_store i_pcm_elastic_store (
        .wclk(clk), .wrst_n(rst_n), .wr_vld(wr_vld), .wr_bit(wr_bit),
        .wr_bitpos(wr_bitpos), .sclk(clk), .srst_n(rst_n), .sct_n(sct_n),
        .ce_n(ce_n), .buf_inh(buf_inh), .ser_out(ser_out), .par_out(par_out),
        .par_bit(par_bit), .par_oe(par_oe), .slip(slip)
    );

    function automatic logic [7:0] slot_val(int s, int k);
        return 8'(k * 29 + s * 71 + 13);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Writer: one bit per clock, sign bit first, stops at a slot boundary.
    initial forever begin
        @(negedge clk);
        if (wr_on) begin
            logic [7:0] v;
            v = slot_val(seed, wr_slot);
            wr_vld    = 1'b1;
            wr_bit    = v[7 - wr_idx];
            wr_bitpos = 3'(wr_idx);
            if (wr_idx == 7) begin
                wr_idx = 0;
                wr_slot++;
                if (wr_slot >= wr_limit) wr_on = 0;
            end else wr_idx++;
        end else begin
            wr_vld = 1'b0;
        end
    end

    task automatic do_reset(int s, bit inh);
        @(negedge clk);
        rst_n = 1'b0; wr_on = 0; sct_n = 1'b1; ce_n = 1'b0; buf_inh = inh;
        repeat (3) @(negedge clk);
        seed = s; wr_slot = 0; wr_idx = 0;
        rst_n = 1'b1;
    endtask

    task automatic write_and_wait(int n);
        wr_limit = n; wr_on = 1;
        wait (wr_on == 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic trigger();
        sct_n = 1'b0;
        @(negedge clk);
        sct_n = 1'b1;
    endtask

    // Checks one slot starting at its first falling edge; act 1 pokes a
    // gated trigger, act 2 fires a real trigger mid-slot and returns early.
    task automatic read_slot(logic [7:0] exp, logic exp_slip, int act, string req);
        for (int i = 0; i < 8; i++) begin
            if (i == 0) begin
                chk(par_out == exp, {req, " R5 R8 par_out"}, par_out, exp);
                chk(par_bit == ^exp, "R6 par_bit", par_bit, ^exp);
                chk(slip == exp_slip, {req, " slip"}, slip, exp_slip);
            end
            chk(ser_out == exp[7 - i], "R4 ser_out", ser_out, exp[7 - i]);
            if (act == 2 && i == 3) begin
                trigger();
                return;
            end
            if (act == 1 && i == 2) begin
                ce_n = 1'b1; sct_n = 1'b0;
                @(negedge clk);
                chk(par_oe == 1'b0, "R7 par_oe off", par_oe, 0);
                chk(par_out == exp, "R3 par_out kept", par_out, exp);
                ce_n = 1'b0; sct_n = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset_quiet();
        do_reset(1, 1'b0);
        wr_limit = 1000; wr_on = 1;
        repeat (40) @(negedge clk);
        chk(par_out == 8'h00, "R1 par_out", par_out, 0);
        chk(ser_out == 1'b0 && slip == 1'b0 && par_bit == 1'b0, "R1 ser/slip/par_bit",
            {ser_out, slip, par_bit}, 0);
        chk(par_oe == 1'b1, "R7 par_oe on", par_oe, 1);
        ce_n = 1'b1;
        #1;
        chk(par_oe == 1'b0, "R7 par_oe off", par_oe, 0);
        ce_n = 1'b0;
    endtask

    task automatic t_stream_and_realign();
        wait (wr_slot >= 20);
        @(negedge clk);
        trigger();
        for (int k = 0; k < 6; k++) read_slot(slot_val(1, k), 1'b0, 0, "R2 R8 stream");
        read_slot(slot_val(1, 6), 1'b0, 1, "R3 gated trigger");
        read_slot(slot_val(1, 7), 1'b0, 0, "R3 sequence kept");
        read_slot(slot_val(1, 8), 1'b0, 0, "R8 stream");
        read_slot(slot_val(1, 9), 1'b0, 2, "R2 before realign");
        read_slot(slot_val(1, 10), 1'b0, 0, "R2 after realign");
        read_slot(slot_val(1, 11), 1'b0, 0, "R2 realigned next");
        wr_on = 0;
    endtask

    task automatic t_underrun(bit inh, int s);
        int back;
        back = inh ? 16 : 24;
        do_reset(s, inh);
        write_and_wait(30);
        trigger();
        for (int k = 0; k < 29; k++) read_slot(slot_val(s, k), 1'b0, 0, "R9 before slip");
        read_slot(slot_val(s, 29 - back), 1'b1, 0, inh ? "R9 R11 inhibit jump" : "R9 normal jump");
        read_slot(slot_val(s, 30 - back), 1'b0, 0, "R9 after slip");
    endtask

    task automatic t_overrun(bit inh, int n, int exp_k, bit exp_slip, int s);
        do_reset(s, inh);
        write_and_wait(n);
        trigger();
        read_slot(slot_val(s, exp_k), exp_slip, 0, inh ? "R10 R11 inhibit lag" : "R10 R11 normal lag");
        read_slot(slot_val(s, exp_k + 1), 1'b0, 0, "R10 next slot");
    endtask

    initial begin
        t_reset_quiet();
        t_stream_and_realign();
        t_underrun(1'b0, 2);
        t_underrun(1'b1, 3);
        t_overrun(1'b1, 40, 16, 1'b1, 4);
        t_overrun(1'b0, 40, 0, 1'b0, 5);
        t_overrun(1'b0, 47, 24, 1'b1, 6);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule